// File: doc/BRIEF.md
# Register-Register Integer Execution Unit

This block is the purely combinational arithmetic and logic stage for three-register instructions that share the all-zero major opcode. It takes two operand words, a shift count and a 6-bit function selector, and produces the result word in the same cycle. It also produces two flags. The first is a trap request for signed overflow. The second marks a selector value the unit does not implement.

The selector is decoded directly from fixed code points into an internal operation select. One adder/subtractor serves addition, subtraction and both magnitude compares. Trapping and non-trapping add/subtract give the same result word and differ only in whether the overflow flag may assert. The shifter acts on the second operand only. A parameter picks between a staged logarithmic shifter and a plain operator form.

Top module: `rtype_alu`

## Requirements
- R1: Selector 0x20 outputs the two's-complement sum of A and B (modulo 2^32). The overflow flag is 1 exactly when A and B share a sign and the sum's sign differs from it.
- R2: Selector 0x21 outputs the same sum as 0x20, and the overflow flag stays 0 for every operand pair.
- R3: Selector 0x22 outputs A minus B (modulo 2^32). The overflow flag is 1 exactly when A and B differ in sign and the difference's sign differs from A's sign.
- R4: Selector 0x23 outputs the same difference as 0x22, and the overflow flag stays 0.
- R5: Selector 0x24 outputs bitwise A AND B, and selector 0x25 outputs bitwise A OR B.
- R6: Selector 0x27 outputs the bitwise complement of (A OR B). With B equal to zero, this is the complement of A.
- R7: Selector 0x00 outputs B shifted left by the shift count (0..31), with zeros entering at bit 0. A has no effect on the result.
- R8: Selector 0x02 outputs B shifted right by the shift count, with zeros entering at bit 31. A has no effect on the result.
- R9: Selector 0x2A outputs 1 when A is less than B as signed two's-complement numbers, and 0 otherwise. Bits 31..1 of the result are zero.
- R10: Selector 0x2B outputs 1 when A is less than B as unsigned numbers, and 0 otherwise.
- R11: Any selector not listed in R1 to R10 drives the result to zero and the illegal-function flag to 1. Listed selectors keep that flag at 0.
- R12: The overflow flag is 0 for every selector other than 0x20 and 0x22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a_i | input | 32 | First source operand (A) |
| opnd_b_i | input | 32 | Second source operand (B); the shifted value for shifts |
| shift_amt_i | input | 5 | Shift count |
| func_i | input | 6 | Function selector |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow trap request |
| bad_func_o | output | 1 | Unimplemented selector |

## Verification
All three outputs are combinational and are due in the same cycle the inputs are applied, with zero register stages on any path. The bench applies a new vector shortly after each rising edge and compares result, overflow and illegal flag with a behavioural model at the following falling edge. This gives the logic a half period to settle and keeps sampling clear of the edge. Directed vectors cover the sign-boundary overflow cases, equal operands for both compares, shift counts 0 and 31, and unlisted selectors. Pseudo-random vectors then exercise every selector.

// File: rtl/rtype_alu_pkg.sv
package rtype_alu_pkg;

   localparam int FUNC_W = 6;

   localparam logic [FUNC_W-1:0] FN_SLL  = 6'h00;
   localparam logic [FUNC_W-1:0] FN_SRL  = 6'h02;
   localparam logic [FUNC_W-1:0] FN_ADD  = 6'h20;
   localparam logic [FUNC_W-1:0] FN_ADDU = 6'h21;
   localparam logic [FUNC_W-1:0] FN_SUB  = 6'h22;
   localparam logic [FUNC_W-1:0] FN_SUBU = 6'h23;
   localparam logic [FUNC_W-1:0] FN_AND  = 6'h24;
   localparam logic [FUNC_W-1:0] FN_OR   = 6'h25;
   localparam logic [FUNC_W-1:0] FN_NOR  = 6'h27;
   localparam logic [FUNC_W-1:0] FN_SLT  = 6'h2A;
   localparam logic [FUNC_W-1:0] FN_SLTU = 6'h2B;

   typedef enum logic [3:0] {
      OP_NONE = 4'd0,
      OP_ADD  = 4'd1,
      OP_ADDU = 4'd2,
      OP_SUB  = 4'd3,
      OP_SUBU = 4'd4,
      OP_AND  = 4'd5,
      OP_OR   = 4'd6,
      OP_NOR  = 4'd7,
      OP_SLL  = 4'd8,
      OP_SRL  = 4'd9,
      OP_SLT  = 4'd10,
      OP_SLTU = 4'd11
   } alu_op_e;

   typedef struct packed {
      alu_op_e op;
      logic    sub_en;
      logic    may_trap;
      logic    bad;
   } alu_sel_t;

endpackage

// File: rtl/rtype_decode.sv
module rtype_decode
   import rtype_alu_pkg::*;
(
   input  logic [FUNC_W-1:0] func_i,
   output alu_sel_t          sel_o
);

   always_comb begin
      sel_o          = '0;
      sel_o.op       = OP_NONE;
      unique case (func_i)
         FN_ADD:  sel_o.op = OP_ADD;
         FN_ADDU: sel_o.op = OP_ADDU;
         FN_SUB:  sel_o.op = OP_SUB;
         FN_SUBU: sel_o.op = OP_SUBU;
         FN_AND:  sel_o.op = OP_AND;
         FN_OR:   sel_o.op = OP_OR;
         FN_NOR:  sel_o.op = OP_NOR;
         FN_SLL:  sel_o.op = OP_SLL;
         FN_SRL:  sel_o.op = OP_SRL;
         FN_SLT:  sel_o.op = OP_SLT;
         FN_SLTU: sel_o.op = OP_SLTU;
         default: sel_o.bad = 1'b1;
      endcase
      sel_o.sub_en   = (sel_o.op == OP_SUB)  || (sel_o.op == OP_SUBU) ||
                       (sel_o.op == OP_SLT)  || (sel_o.op == OP_SLTU);
      sel_o.may_trap = (sel_o.op == OP_ADD)  || (sel_o.op == OP_SUB);
   end

endmodule

// File: rtl/rtype_addsub.sv
module rtype_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              ovf_o,
   output logic              lt_s_o,
   output logic              lt_u_o
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   wide;

   always_comb begin
      b_eff = sub_i ? ~b_i : b_i;
      wide  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
   end

   assign sum_o  = wide[MSB:0];
   // same-sign inputs to the adder with a flipped result sign
   assign ovf_o  = (a_i[MSB] == b_eff[MSB]) && (wide[MSB] != a_i[MSB]);
   assign lt_s_o = wide[MSB] ^ ovf_o;
   // when subtracting, missing carry-out is a borrow
   assign lt_u_o = ~wide[DATA_W];

endmodule

// File: rtl/rtype_shift.sv
module rtype_shift #(
   parameter int DATA_W     = 32,
   parameter bit SHIFT_LEFT = 1'b1,
   parameter bit STAGED     = 1'b1,
   localparam int AMT_W     = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din_i,
   input  logic [AMT_W-1:0]  amt_i,
   output logic [DATA_W-1:0] dout_o
);

   if (STAGED) begin : g_staged
      logic [DATA_W-1:0] stg [0:AMT_W];
      assign stg[0] = din_i;
      for (genvar k = 0; k < AMT_W; k++) begin : g_stage
         localparam int STEP = 1 << k;
         logic [DATA_W-1:0] moved;
         if (SHIFT_LEFT) begin : g_l
            assign moved = {stg[k][DATA_W-1-STEP:0], {STEP{1'b0}}};
         end else begin : g_r
            assign moved = {{STEP{1'b0}}, stg[k][DATA_W-1:STEP]};
         end
         assign stg[k+1] = amt_i[k] ? moved : stg[k];
      end
      assign dout_o = stg[AMT_W];
   end else begin : g_flat
      if (SHIFT_LEFT) begin : g_l
         assign dout_o = din_i << amt_i;
      end else begin : g_r
         assign dout_o = din_i >> amt_i;
      end
   end

endmodule

// File: rtl/rtype_alu.sv
module rtype_alu
   import rtype_alu_pkg::*;
#(
   parameter int  DATA_W        = 32,
   parameter bit  SHIFT_STAGED  = 1'b1,
   localparam int SHAMT_W       = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0]  opnd_a_i,
   input  logic [DATA_W-1:0]  opnd_b_i,
   input  logic [SHAMT_W-1:0] shift_amt_i,
   input  logic [FUNC_W-1:0]  func_i,
   output logic [DATA_W-1:0]  result_o,
   output logic               ovf_o,
   output logic               bad_func_o
);

   if (DATA_W < 8) begin : g_chk_min
      $error("rtype_alu: DATA_W must be at least 8");
   end
   if ((DATA_W & (DATA_W - 1)) != 0) begin : g_chk_pow2
      $error("rtype_alu: DATA_W must be a power of two");
   end

   alu_sel_t          sel;
   logic [DATA_W-1:0] arith;
   logic              arith_ovf;
   logic              lt_s;
   logic              lt_u;
   logic [DATA_W-1:0] shl;
   logic [DATA_W-1:0] shr;

   rtype_decode u_dec (
      .func_i (func_i),
      .sel_o  (sel)
   );

   rtype_addsub #(.DATA_W(DATA_W)) u_arith (
      .a_i    (opnd_a_i),
      .b_i    (opnd_b_i),
      .sub_i  (sel.sub_en),
      .sum_o  (arith),
      .ovf_o  (arith_ovf),
      .lt_s_o (lt_s),
      .lt_u_o (lt_u)
   );

   rtype_shift #(.DATA_W(DATA_W), .SHIFT_LEFT(1'b1), .STAGED(SHIFT_STAGED)) u_shl (
      .din_i  (opnd_b_i),
      .amt_i  (shift_amt_i),
      .dout_o (shl)
   );

   rtype_shift #(.DATA_W(DATA_W), .SHIFT_LEFT(1'b0), .STAGED(SHIFT_STAGED)) u_shr (
      .din_i  (opnd_b_i),
      .amt_i  (shift_amt_i),
      .dout_o (shr)
   );

   always_comb begin
      unique case (sel.op)
         OP_ADD, OP_ADDU,
         OP_SUB, OP_SUBU: result_o = arith;
         OP_AND:          result_o = opnd_a_i & opnd_b_i;
         OP_OR:           result_o = opnd_a_i | opnd_b_i;
         OP_NOR:          result_o = ~(opnd_a_i | opnd_b_i);
         OP_SLL:          result_o = shl;
         OP_SRL:          result_o = shr;
         OP_SLT:          result_o = {{(DATA_W-1){1'b0}}, lt_s};
         OP_SLTU:         result_o = {{(DATA_W-1){1'b0}}, lt_u};
         default:         result_o = '0;
      endcase
   end

   assign ovf_o      = sel.may_trap & arith_ovf;
   assign bad_func_o = sel.bad;

endmodule

// File: rtl/rtype_alu_chk.sv
module rtype_alu_chk
   import rtype_alu_pkg::*;
#(
   parameter int  DATA_W  = 32,
   localparam int SHAMT_W = $clog2(DATA_W)
) (
   input logic [DATA_W-1:0]  opnd_a_i,
   input logic [DATA_W-1:0]  opnd_b_i,
   input logic [SHAMT_W-1:0] shift_amt_i,
   input logic [FUNC_W-1:0]  func_i,
   input logic [DATA_W-1:0]  result_o,
   input logic               ovf_o,
   input logic               bad_func_o
);

   logic [DATA_W-1:0] ones;
   logic [DATA_W-1:0] keep_hi;
   logic [DATA_W-1:0] keep_lo;

   always_comb begin
      ones    = '1;
      keep_hi = ones << shift_amt_i;
      keep_lo = ones >> shift_amt_i;
      if (func_i != FN_ADD && func_i != FN_SUB) begin
         p_no_overflow_r12: assert (!ovf_o);
      end
      if (bad_func_o) begin
         p_illegal_zero_r11: assert (result_o == '0);
      end
      if (func_i == FN_SLT || func_i == FN_SLTU) begin
         p_cmp_single_bit_r9: assert (result_o[DATA_W-1:1] == '0);
      end
      if (func_i == FN_SLL) begin
         p_sll_low_zero_r7: assert ((result_o & ~keep_hi) == '0);
      end
      if (func_i == FN_SRL) begin
         p_srl_high_zero_r8: assert ((result_o & ~keep_lo) == '0);
      end
      if (func_i == FN_AND) begin
         p_and_subset_r5: assert ((result_o & ~(opnd_a_i & opnd_b_i)) == '0);
      end
      if (func_i == FN_NOR) begin
         p_nor_disjoint_r6: assert ((result_o & (opnd_a_i | opnd_b_i)) == '0);
      end
   end

endmodule

bind rtype_alu rtype_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_rtype_alu.sv
module tb_rtype_alu;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a, b;
   logic [4:0]   sh;
   logic [5:0]   fn;
   logic [W-1:0] res;
   logic         ovf, bad;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #4 clk = ~clk;   // 125 MHz

   rtype_alu dut (
      .opnd_a_i    (a),
      .opnd_b_i    (b),
      .shift_amt_i (sh),
      .func_i      (fn),
      .result_o    (res),
      .ovf_o       (ovf),
      .bad_func_o  (bad)
   );

   function automatic string tag_of(input logic [5:0] f);
      case (f)
         6'h20: return "R1";
         6'h21: return "R2";
         6'h22: return "R3";
         6'h23: return "R4";
         6'h24, 6'h25: return "R5";
         6'h27: return "R6";
         6'h00: return "R7";
         6'h02: return "R8";
         6'h2A: return "R9";
         6'h2B: return "R10";
         default: return "R11";
      endcase
   endfunction

   // behavioural reference using wide integer arithmetic
   task automatic model(input logic [W-1:0] ma, input logic [W-1:0] mb,
                        input logic [4:0] ms, input logic [5:0] mf,
                        output logic [W-1:0] er, output logic eo, output logic eb);
      longint sa, sb, wide;
      longint unsigned ua, ub;
      sa = longint'($signed(ma));
      sb = longint'($signed(mb));
      ua = {32'd0, ma};
      ub = {32'd0, mb};
      er = '0; eo = 1'b0; eb = 1'b0;
      case (mf)
         6'h20, 6'h21: begin
            wide = sa + sb;
            er   = W'(ua + ub);
            if (mf == 6'h20) eo = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
         end
         6'h22, 6'h23: begin
            wide = sa - sb;
            er   = W'(ua - ub);
            if (mf == 6'h22) eo = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
         end
         6'h24: er = ma & mb;
         6'h25: er = ma | mb;
         6'h27: er = ~(ma | mb);
         6'h00: er = W'(ub * (64'd1 << ms));
         6'h02: er = W'(ub / (64'd1 << ms));
         6'h2A: er = (sa < sb) ? 1 : 0;
         6'h2B: er = (ua < ub) ? 1 : 0;
         default: eb = 1'b1;
      endcase
   endtask

   task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb_,
                        input logic [4:0] ts, input logic [5:0] tf);
      logic [W-1:0] er;
      logic eo, eb;
      string t;
      @(posedge clk);
      #1;
      a = ta; b = tb_; sh = ts; fn = tf;
      @(negedge clk);
      model(ta, tb_, ts, tf, er, eo, eb);
      n_vec++;
      t = tag_of(tf);
      if (res !== er || ovf !== eo || bad !== eb) begin
         n_fail++;
         if (ovf !== eo && tf != 6'h20 && tf != 6'h22 && tf != 6'h21 && tf != 6'h23) t = "R12";
         $display("FAIL %s fn=%02h a=%08h b=%08h sh=%0d: got res=%08h ovf=%b bad=%b exp res=%08h ovf=%b bad=%b",
                  t, tf, ta, tb_, ts, res, ovf, bad, er, eo, eb);
      end
   endtask

   logic [31:0] lfsr = 32'h1ACE_B00C;
   function automatic logic [31:0] step(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   initial begin
      a = '0; b = '0; sh = '0; fn = 6'h00;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset-time inputs: sll of zero gives zero (R7)
      apply(32'h0, 32'h0, 5'd0, 6'h00);
      // R1 overflow corners
      apply(32'h7FFF_FFFF, 32'h1, 5'd0, 6'h20);
      apply(32'h8000_0000, 32'hFFFF_FFFF, 5'd0, 6'h20);
      apply(32'h7FFF_FFFF, 32'h8000_0000, 5'd0, 6'h20);
      apply(32'h0000_1234, 32'h0000_4321, 5'd0, 6'h20);
      // R2 same sums, no overflow
      apply(32'h7FFF_FFFF, 32'h1, 5'd0, 6'h21);
      apply(32'h8000_0000, 32'h8000_0000, 5'd0, 6'h21);
      // R3 subtract corners
      apply(32'h8000_0000, 32'h1, 5'd0, 6'h22);
      apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, 6'h22);
      apply(32'h0, 32'h8000_0000, 5'd0, 6'h22);
      apply(32'hFFFF_FFFF, 32'h8000_0000, 5'd0, 6'h22);
      // R4
      apply(32'h8000_0000, 32'h1, 5'd0, 6'h23);
      apply(32'h0, 32'h1, 5'd0, 6'h23);
      // R5, R6 (nor with zero acts as not)
      apply(32'hF0F0_1234, 32'h0FF0_FFFF, 5'd0, 6'h24);
      apply(32'hF0F0_1234, 32'h0FF0_0000, 5'd0, 6'h25);
      apply(32'hA5A5_5A5A, 32'h0, 5'd0, 6'h27);
      apply(32'h1234_0000, 32'h0000_5678, 5'd0, 6'h27);
      // R7, R8 with A nonzero, counts 0 and 31
      apply(32'hFFFF_FFFF, 32'h8000_0001, 5'd0, 6'h00);
      apply(32'hFFFF_FFFF, 32'h8000_0001, 5'd31, 6'h00);
      apply(32'hDEAD_BEEF, 32'h0000_00FF, 5'd4, 6'h00);
      apply(32'hFFFF_FFFF, 32'h8000_0001, 5'd31, 6'h02);
      apply(32'h0, 32'hF000_0000, 5'd4, 6'h02);
      apply(32'h0, 32'h8000_0000, 5'd0, 6'h02);
      // R9, R10
      apply(32'hFFFF_FFFF, 32'h1, 5'd0, 6'h2A);
      apply(32'hFFFF_FFFF, 32'h1, 5'd0, 6'h2B);
      apply(32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 6'h2A);
      apply(32'h5, 32'h5, 5'd0, 6'h2A);
      apply(32'h5, 32'h5, 5'd0, 6'h2B);
      apply(32'h4, 32'h5, 5'd0, 6'h2B);
      // R11 unlisted selectors
      apply(32'h7FFF_FFFF, 32'h1, 5'd3, 6'h01);
      apply(32'h1234_5678, 32'h9ABC_DEF0, 5'd3, 6'h26);
      apply(32'h1234_5678, 32'h9ABC_DEF0, 5'd3, 6'h3F);
      apply(32'h1234_5678, 32'h9ABC_DEF0, 5'd3, 6'h03);
      // random sweep: legal selectors mostly, any 6-bit code sometimes (R1..R12)
      for (int i = 0; i < 600; i++) begin
         logic [31:0] ra, rb, rc;
         logic [5:0]  rf;
         lfsr = step(lfsr); ra = lfsr;
         lfsr = step(lfsr); rb = lfsr;
         lfsr = step(lfsr); rc = lfsr;
         case (rc[11:8])
            4'd0: rf = 6'h20;  4'd1: rf = 6'h21;  4'd2: rf = 6'h22;
            4'd3: rf = 6'h23;  4'd4: rf = 6'h24;  4'd5: rf = 6'h25;
            4'd6: rf = 6'h27;  4'd7: rf = 6'h00;  4'd8: rf = 6'h02;
            4'd9: rf = 6'h2A;  4'd10: rf = 6'h2B;
            default: rf = rc[21:16];
         endcase
         if (rc[3]) rb = {rb[31], ra[30:0]};
         apply(ra, rb, rc[28:24], rf);
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule